// File: doc/BRIEF.md
# Status Register Write and Flag Unit

This unit keeps the current processor status word and a saved copy of it for each privileged bank. A move-to-status instruction writes the current word or the saved word of the active bank. Bits 19:16 of the instruction word choose which fields of the word change, and the active bank decides whether the write is restricted. On a separate path, an arithmetic result and its two operands update the four condition flags. A select input tells the unit whether the operation was an addition or a subtraction.

Field layout: the condition flags N, Z, C, V sit in bits 31:28, from most to least significant. The two interrupt-disable bits are bits 7:6 and the mode field is bits 4:0. The bank input is encoded as 0 = user, 1..5 = the five privileged banks that have a saved word, and 6..7 = dummy banks. A dummy bank counts as privileged for writes to the current word but has no saved word. Every write lands on the rising clock edge. The flag outputs are the flag bits of the current word. The mode-change strobe is registered.

Top module: `sr_status_unit`

## Requirements
- R1: Out of reset, cur_status equals 32'h0000_00D3, every saved word is zero, and mode_chg is low.
- R2: With wr_cur high in bank 0, only bits 31:28 take wr_data, and only if instr[19] is 1. If instr[19] is 0, the word does not change.
- R3: With wr_cur high in any bank other than 0, instr[19:16] = 4'b1001 loads all 32 bits from wr_data.
- R4: With wr_cur high in a bank other than 0 and instr[19:16] not equal to 4'b1001, instr[16] = 1 loads only bits 7:6 and 4:0.
- R5: With wr_cur high in a bank other than 0, instr[19:16] not equal to 4'b1001 and instr[16] = 0, instr[19] = 1 loads only bits 31:28. If instr[19] is also 0, nothing changes.
- R6: wr_sav in banks 1..5 updates that bank's saved word using the field selection of R3 to R5. wr_sav in banks 0, 6 and 7 changes nothing.
- R7: sav_status shows the active bank's saved word in banks 1..5 and shows cur_status in banks 0, 6 and 7.
- R8: With flag_en high, wr_cur low and is_sub = 0, C becomes the carry out of op_a + op_b and V becomes signed overflow of that sum. Bits 27:0 keep their value.
- R9: With flag_en high, wr_cur low and is_sub = 1, C becomes 1 exactly when op_a >= op_b unsigned (no borrow). V becomes signed overflow of op_a - op_b.
- R10: On a flag update, N becomes result[31] and Z becomes 1 exactly when result is zero.
- R11: mode_chg is high for exactly the one cycle after a current-word write that changed bits 4:0, and low otherwise.
- R12: When wr_cur and flag_en are high together, the instruction write wins. With both low, cur_status holds its value.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_cur | input | 1 | Move-to-status write of the current word |
| wr_sav | input | 1 | Move-to-status write of the active bank's saved word |
| instr | input | 32 | Instruction word; bits 19:16 select fields |
| wr_data | input | 32 | Value to write |
| bank | input | 3 | Active register bank |
| flag_en | input | 1 | Update flags from the arithmetic inputs |
| is_sub | input | 1 | 1 = subtraction, 0 = addition |
| op_a | input | 32 | First arithmetic operand |
| op_b | input | 32 | Second arithmetic operand |
| result | input | 32 | Arithmetic result |
| cur_status | output | 32 | Current status word |
| sav_status | output | 32 | Saved word of the active bank, or the current word |
| flag_n | output | 1 | Negative flag |
| flag_z | output | 1 | Zero flag |
| flag_c | output | 1 | Carry flag |
| flag_v | output | 1 | Overflow flag |
| mode_chg | output | 1 | One-cycle strobe after a mode-field change |

## Verification
The bench sweeps all sixteen selector codes in all eight banks, for both the current and the saved word.

- A decoder that tested bit 16 before the full-word code would load only the control field for code 9.
- A decoder that ignored the user restriction would let bank 0 change the mode.
- Flags are driven with edge operands (zero, one, the most positive, the most negative and all-ones) for both add and subtract. A swapped borrow sense or a sign rule taken from the wrong operand then shows up as a wrong C or V.
- The strobe is checked in the cycle after every write and in the idle cycle that follows. A level-held or combinational strobe would fail there.

// File: rtl/sr_pkg.sv
package sr_pkg;
   localparam int unsigned BANK_W      = 3;
   localparam int unsigned SAVED_BANKS = 5;
   localparam int unsigned FLAG_W      = 4;

   typedef enum logic [BANK_W-1:0] {
      BK_USER  = 3'd0,
      BK_FAST  = 3'd1,
      BK_IRQ   = 3'd2,
      BK_SUPV  = 3'd3,
      BK_ABORT = 3'd4,
      BK_UNDEF = 3'd5,
      BK_NONEA = 3'd6,
      BK_NONEB = 3'd7
   } bank_e;

   function automatic logic bank_has_saved(input logic [BANK_W-1:0] b);
      return (b >= BK_FAST) && (b <= BK_UNDEF);
   endfunction
endpackage

// File: rtl/sr_field_mask.sv
module sr_field_mask #(
   parameter int unsigned DATA_W   = 32,
   parameter int unsigned MODE_W   = 5,
   parameter int unsigned IRQ_LSB  = 6,
   parameter int unsigned IRQ_W    = 2,
   parameter int unsigned FLAG_W   = 4,
   parameter logic [3:0]  FULL_SEL = 4'b1001
) (
   input  logic              restrict_user,
   input  logic [3:0]        sel,
   output logic [DATA_W-1:0] mask
);
   localparam logic [DATA_W-1:0] ONES      = '1;
   localparam logic [DATA_W-1:0] FLAG_MASK = ONES << (DATA_W - FLAG_W);
   localparam logic [DATA_W-1:0] MODE_MASK = ONES >> (DATA_W - MODE_W);
   localparam logic [DATA_W-1:0] IRQ_MASK  = (ONES >> (DATA_W - IRQ_W)) << IRQ_LSB;
   localparam logic [DATA_W-1:0] CTRL_MASK = MODE_MASK | IRQ_MASK;

   // Priority decode: full word, then control field, then flag field.
   always_comb begin
      if (restrict_user)
         mask = sel[3] ? FLAG_MASK : '0;
      else if (sel == FULL_SEL)
         mask = ONES;
      else if (sel[0])
         mask = CTRL_MASK;
      else if (sel[3])
         mask = FLAG_MASK;
      else
         mask = '0;
   end
endmodule

// File: rtl/sr_flag_calc.sv
module sr_flag_calc #(
   parameter int unsigned DATA_W = 32
) (
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] result,
   input  logic              is_sub,
   output logic              n_o,
   output logic              z_o,
   output logic              c_o,
   output logic              v_o
);
   localparam int unsigned MSB = DATA_W - 1;

   logic neg_a, neg_b, neg_r;

   always_comb begin
      neg_a = op_a[MSB];
      neg_b = op_b[MSB];
      neg_r = result[MSB];
      n_o   = neg_r;
      z_o   = (result == '0);
      if (is_sub) begin
         c_o = (neg_a & ~neg_b) | (neg_a & ~neg_r) | (~neg_b & ~neg_r);
         v_o = (neg_a & ~neg_b & ~neg_r) | (~neg_a & neg_b & neg_r);
      end else begin
         c_o = (neg_a & neg_b) | (neg_a & ~neg_r) | (neg_b & ~neg_r);
         v_o = (neg_a & neg_b & ~neg_r) | (~neg_a & ~neg_b & neg_r);
      end
   end
endmodule

// File: rtl/sr_saved_bank.sv
module sr_saved_bank #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned NUM    = 5
) (
   input  logic                             clk,
   input  logic                             rst_n,
   input  logic                             wr_en,
   input  logic [$clog2(NUM)-1:0]           slot,
   input  logic [DATA_W-1:0]                mask,
   input  logic [DATA_W-1:0]                data,
   output logic [NUM-1:0][DATA_W-1:0]       words
);
   localparam int unsigned SLOT_W = $clog2(NUM);

   for (genvar i = 0; i < NUM; i++) begin : g_slot
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)
            words[i] <= '0;
         else if (wr_en && (slot == SLOT_W'(i)))
            words[i] <= (words[i] & ~mask) | (data & mask);
      end
   end
endmodule

// File: rtl/sr_status_unit.sv
module sr_status_unit
   import sr_pkg::*;
#(
   parameter int unsigned       DATA_W    = 32,
   parameter int unsigned       INSTR_W   = 32,
   parameter int unsigned       SEL_LSB   = 16,
   parameter int unsigned       MODE_W    = 5,
   parameter int unsigned       IRQ_LSB   = 6,
   parameter int unsigned       IRQ_W     = 2,
   parameter logic [3:0]        FULL_SEL  = 4'b1001,
   parameter logic [DATA_W-1:0] RESET_VAL = 32'h0000_00D3
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              wr_cur,
   input  logic              wr_sav,
   input  logic [INSTR_W-1:0] instr,
   input  logic [DATA_W-1:0] wr_data,
   input  logic [2:0]        bank,
   input  logic              flag_en,
   input  logic              is_sub,
   input  logic [DATA_W-1:0] op_a,
   input  logic [DATA_W-1:0] op_b,
   input  logic [DATA_W-1:0] result,
   output logic [DATA_W-1:0] cur_status,
   output logic [DATA_W-1:0] sav_status,
   output logic              flag_n,
   output logic              flag_z,
   output logic              flag_c,
   output logic              flag_v,
   output logic              mode_chg
);
   localparam int unsigned SLOT_W   = $clog2(SAVED_BANKS);
   localparam int unsigned FLAG_LSB = DATA_W - FLAG_W;

   // Elaboration-time configuration checks
   if (DATA_W < 8)
      begin : g_bad_width $error("status word too narrow"); end
   if (IRQ_LSB + IRQ_W > FLAG_LSB)
      begin : g_bad_irq $error("interrupt bits overlap flag field"); end
   if (MODE_W > IRQ_LSB || MODE_W == 0)
      begin : g_bad_mode $error("mode field overlaps interrupt bits"); end
   if (SEL_LSB + 4 > INSTR_W)
      begin : g_bad_sel $error("selector lies outside instruction word"); end

   logic [3:0]        sel;
   logic              user_bank;
   logic              has_saved;
   logic [SLOT_W-1:0] slot;
   logic [DATA_W-1:0] cur_mask, sav_mask;
   logic [DATA_W-1:0] cur_q, cur_nxt;
   logic              mode_chg_q;
   logic              fn, fz, fc, fv;
   logic [SAVED_BANKS-1:0][DATA_W-1:0] saved_words;

   assign sel       = instr[SEL_LSB +: 4];
   assign user_bank = (bank == BK_USER);
   assign has_saved = bank_has_saved(bank);
   assign slot      = SLOT_W'(bank - 3'd1);

   if (INSTR_W > SEL_LSB + 4 && SEL_LSB > 0) begin : g_unused_both
      logic unused_instr_bits;
      assign unused_instr_bits = ^{instr[INSTR_W-1:SEL_LSB+4], instr[SEL_LSB-1:0]};
   end else if (SEL_LSB > 0) begin : g_unused_low
      logic unused_instr_bits;
      assign unused_instr_bits = ^instr[SEL_LSB-1:0];
   end else if (INSTR_W > SEL_LSB + 4) begin : g_unused_high
      logic unused_instr_bits;
      assign unused_instr_bits = ^instr[INSTR_W-1:SEL_LSB+4];
   end

   sr_field_mask #(
      .DATA_W(DATA_W), .MODE_W(MODE_W), .IRQ_LSB(IRQ_LSB),
      .IRQ_W(IRQ_W), .FLAG_W(FLAG_W), .FULL_SEL(FULL_SEL)
   ) u_cur_mask (
      .restrict_user(user_bank), .sel(sel), .mask(cur_mask)
   );

   sr_field_mask #(
      .DATA_W(DATA_W), .MODE_W(MODE_W), .IRQ_LSB(IRQ_LSB),
      .IRQ_W(IRQ_W), .FLAG_W(FLAG_W), .FULL_SEL(FULL_SEL)
   ) u_sav_mask (
      .restrict_user(1'b0), .sel(sel), .mask(sav_mask)
   );

   sr_flag_calc #(.DATA_W(DATA_W)) u_flags (
      .op_a(op_a), .op_b(op_b), .result(result), .is_sub(is_sub),
      .n_o(fn), .z_o(fz), .c_o(fc), .v_o(fv)
   );

   sr_saved_bank #(.DATA_W(DATA_W), .NUM(SAVED_BANKS)) u_saved (
      .clk(clk), .rst_n(rst_n), .wr_en(wr_sav && has_saved),
      .slot(slot), .mask(sav_mask), .data(wr_data), .words(saved_words)
   );

   // Instruction write takes priority over the arithmetic flag path.
   always_comb begin
      cur_nxt = cur_q;
      if (wr_cur)
         cur_nxt = (cur_q & ~cur_mask) | (wr_data & cur_mask);
      else if (flag_en)
         cur_nxt[DATA_W-1 -: FLAG_W] = {fn, fz, fc, fv};
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cur_q      <= RESET_VAL;
         mode_chg_q <= 1'b0;
      end else begin
         cur_q      <= cur_nxt;
         mode_chg_q <= wr_cur && (cur_nxt[MODE_W-1:0] != cur_q[MODE_W-1:0]);
      end
   end

   assign cur_status = cur_q;
   assign sav_status = has_saved ? saved_words[slot] : cur_q;
   assign flag_n     = cur_q[DATA_W-1];
   assign flag_z     = cur_q[DATA_W-2];
   assign flag_c     = cur_q[DATA_W-3];
   assign flag_v     = cur_q[DATA_W-4];
   assign mode_chg   = mode_chg_q;
endmodule

// File: rtl/sr_status_unit_chk.sv
module sr_status_unit_chk #(
   parameter int unsigned DATA_W = 32,
   parameter int unsigned MODE_W = 5
) (
   input logic              clk,
   input logic              rst_n,
   input logic              wr_cur,
   input logic              flag_en,
   input logic [2:0]        bank,
   input logic [DATA_W-1:0] result,
   input logic [DATA_W-1:0] cur_status,
   input logic [DATA_W-1:0] sav_status,
   input logic              flag_n,
   input logic              flag_z,
   input logic              mode_chg
);
   localparam int unsigned LOW_W = DATA_W - 4;

   assert_user_flags_only_R2: assert property (@(posedge clk) disable iff (!rst_n)
      (wr_cur && bank == 3'd0) |=> $stable(cur_status[LOW_W-1:0]));

   assert_saved_fallback_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (bank == 3'd0 || bank >= 3'd6) |-> (sav_status == cur_status));

   assert_flag_scope_R8: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !wr_cur) |=> $stable(cur_status[LOW_W-1:0]));

   assert_zero_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !wr_cur) |=> (flag_z == ($past(result) == '0)));

   assert_neg_flag_R10: assert property (@(posedge clk) disable iff (!rst_n)
      (flag_en && !wr_cur) |=> (flag_n == $past(result[DATA_W-1])));

   assert_strobe_cause_R11: assert property (@(posedge clk) disable iff (!rst_n)
      mode_chg |-> (cur_status[MODE_W-1:0] != $past(cur_status[MODE_W-1:0])));

   assert_strobe_seen_R11: assert property (@(posedge clk) disable iff (!rst_n)
      (cur_status[MODE_W-1:0] != $past(cur_status[MODE_W-1:0])) |-> mode_chg);

   assert_idle_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
      (!wr_cur && !flag_en) |=> $stable(cur_status));
endmodule

bind sr_status_unit sr_status_unit_chk #(.DATA_W(DATA_W), .MODE_W(MODE_W)) u_chk (
   .clk(clk), .rst_n(rst_n), .wr_cur(wr_cur), .flag_en(flag_en), .bank(bank),
   .result(result), .cur_status(cur_status), .sav_status(sav_status),
   .flag_n(flag_n), .flag_z(flag_z), .mode_chg(mode_chg)
);

// File: tb/sr_status_unit_tb.sv
`timescale 1ns/1ps
module sr_status_unit_tb;
   logic        clk = 1'b0;
   logic        rst_n;
   logic        wr_cur, wr_sav, flag_en, is_sub;
   logic [31:0] instr, wr_data, op_a, op_b, result;
   logic [2:0]  bank;
   logic [31:0] cur_status, sav_status;
   logic        flag_n, flag_z, flag_c, flag_v, mode_chg;

   int n_tests = 0;
   int n_fail  = 0;
   bit done    = 0;

   logic [31:0] exp_cur;
   logic [31:0] exp_sav [8];

   always #2.5 clk = ~clk;

   sr_status_unit u_dut (
      .clk(clk), .rst_n(rst_n), .wr_cur(wr_cur), .wr_sav(wr_sav),
      .instr(instr), .wr_data(wr_data), .bank(bank), .flag_en(flag_en),
      .is_sub(is_sub), .op_a(op_a), .op_b(op_b), .result(result),
      .cur_status(cur_status), .sav_status(sav_status),
      .flag_n(flag_n), .flag_z(flag_z), .flag_c(flag_c), .flag_v(flag_v),
      .mode_chg(mode_chg)
   );

   task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
      n_tests++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s: actual %h expected %h", tag, act, exp);
      end
   endtask

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   function automatic logic [31:0] field_mask(input bit user, input logic [3:0] s);
      if (user)           return s[3] ? 32'hF000_0000 : 32'h0;
      if (s == 4'b1001)   return 32'hFFFF_FFFF;
      if (s[0])           return 32'h0000_00DF;
      if (s[3])           return 32'hF000_0000;
      return 32'h0;
   endfunction

   initial begin
      logic [31:0] vals [8];
      vals[0] = 32'h0000_0000; vals[1] = 32'h0000_0001;
      vals[2] = 32'h7FFF_FFFF; vals[3] = 32'h8000_0000;
      vals[4] = 32'hFFFF_FFFF; vals[5] = 32'h8000_0001;
      vals[6] = 32'h1234_5678; vals[7] = 32'hFEDC_BA98;

      rst_n = 1'b0; wr_cur = 0; wr_sav = 0; flag_en = 0; is_sub = 0;
      instr = '0; wr_data = '0; bank = 3'd0; op_a = '0; op_b = '0; result = '0;
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1: reset state
      exp_cur = 32'h0000_00D3;
      check("R1 cur_status", cur_status, exp_cur);
      check("R1 mode_chg", {31'h0, mode_chg}, 32'h0);
      for (int b = 0; b < 8; b++) begin
         bank = 3'(b);
         exp_sav[b] = 32'h0;
         #1;
         check("R1 saved word", sav_status, (b >= 1 && b <= 5) ? 32'h0 : exp_cur);
      end

      // R2..R5, R11: current-word writes across banks and selectors
      for (int b = 0; b < 8; b++) begin
         for (int s = 0; s < 16; s++) begin
            logic [31:0] d, m, old;
            d = 32'h9E37_79B9 * 32'(b * 16 + s + 1);
            m = field_mask(b == 0, 4'(s));
            old = exp_cur;
            bank = 3'(b); instr = {12'h0, 4'(s), 16'h0}; wr_data = d; wr_cur = 1'b1;
            step();
            exp_cur = (old & ~m) | (d & m);
            if (b == 0)        check("R2 user write", cur_status, exp_cur);
            else if (s == 9)   check("R3 full write", cur_status, exp_cur);
            else if (s[0])     check("R4 control write", cur_status, exp_cur);
            else               check("R5 flag or none write", cur_status, exp_cur);
            check("R11 strobe after write", {31'h0, mode_chg},
                  {31'h0, exp_cur[4:0] != old[4:0]});
            wr_cur = 1'b0;
            step();
            check("R11 strobe one cycle", {31'h0, mode_chg}, 32'h0);
         end
      end

      // R6: saved-word writes
      for (int b = 0; b < 8; b++) begin
         for (int s = 0; s < 16; s++) begin
            logic [31:0] d;
            d = 32'hC2B2_AE35 * 32'(b * 16 + s + 7);
            bank = 3'(b); instr = {12'h0, 4'(s), 16'h0}; wr_data = d; wr_sav = 1'b1;
            step();
            if (b >= 1 && b <= 5)
               exp_sav[b] = (exp_sav[b] & ~field_mask(0, 4'(s))) | (d & field_mask(0, 4'(s)));
            check("R6 saved write", sav_status, (b >= 1 && b <= 5) ? exp_sav[b] : exp_cur);
            check("R6 current untouched", cur_status, exp_cur);
            wr_sav = 1'b0;
         end
      end

      // R7: read selection per bank
      for (int b = 0; b < 8; b++) begin
         bank = 3'(b);
         #1;
         check("R7 saved read", sav_status, (b >= 1 && b <= 5) ? exp_sav[b] : exp_cur);
      end

      // R8, R9, R10: flags from arithmetic
      bank = 3'd3;
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            for (int k = 0; k < 2; k++) begin
               logic [31:0] a, bb, r;
               logic [32:0] wide, sx;
               logic ec, ev;
               a = vals[i]; bb = vals[j];
               if (k == 0) begin
                  wide = {1'b0, a} + {1'b0, bb};
                  r    = wide[31:0];
                  ec   = wide[32];
                  sx   = {a[31], a} + {bb[31], bb};
               end else begin
                  r    = a - bb;
                  ec   = (a >= bb);
                  sx   = {a[31], a} - {bb[31], bb};
               end
               ev = sx[32] ^ sx[31];
               op_a = a; op_b = bb; result = r; is_sub = k[0]; flag_en = 1'b1;
               step();
               exp_cur = {r[31], r == 32'h0, ec, ev, exp_cur[27:0]};
               if (k == 0) begin
                  check("R8 add C", {31'h0, flag_c}, {31'h0, ec});
                  check("R8 add V", {31'h0, flag_v}, {31'h0, ev});
                  check("R8 low bits kept", cur_status, exp_cur);
               end else begin
                  check("R9 sub C", {31'h0, flag_c}, {31'h0, ec});
                  check("R9 sub V", {31'h0, flag_v}, {31'h0, ev});
                  check("R9 low bits kept", cur_status, exp_cur);
               end
               check("R10 N", {31'h0, flag_n}, {31'h0, r[31]});
               check("R10 Z", {31'h0, flag_z}, {31'h0, r == 32'h0});
            end
         end
      end

      // R12: priority of instruction write, then hold when idle
      op_a = 32'h8000_0000; op_b = 32'h8000_0000; result = 32'h0; is_sub = 1'b0;
      flag_en = 1'b1; wr_cur = 1'b1; bank = 3'd2;
      instr = {12'h0, 4'b1001, 16'h0}; wr_data = 32'h5A5A_0013;
      step();
      exp_cur = 32'h5A5A_0013;
      check("R12 write beats flags", cur_status, exp_cur);
      wr_cur = 1'b0; flag_en = 1'b0; wr_data = 32'hFFFF_FFFF; result = 32'h1234;
      step();
      check("R12 idle hold", cur_status, exp_cur);
      step();
      check("R12 idle hold second", cur_status, exp_cur);

      done = 1;
      $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
      $finish;
   end

   initial begin
      repeat (150000) @(posedge clk);
      if (!done) begin
         n_tests++;
         n_fail++;
         $display("FAIL watchdog R1..: actual timeout expected completion");
         $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
         $finish;
      end
   end
endmodule